// File: doc/BRIEF.md
# Audio Event Interrupt and Frame-Match Unit

This block gathers the interrupt sources of a serial audio interface into one 32-bit control word and drives a single level-sensitive interrupt line. Seven event strobes come from the neighbouring serializer, codec messaging and metering logic. The eighth source is internal: a frame counter that counts a per-frame strobe and is compared against a value that software programs.

Every source owns one enable bit and one sticky pending bit. An event always records itself in its pending bit. The interrupt line is raised while any source has both bits set. Software reaches the control word, the frame counter and the match value through a plain word-wide register port. Writes are accepted in one cycle, and reads return the selected word combinationally from the address.

Top module: `aud_evt_irq_unit`

## Requirements
- R1: After reset the enables, the pending bits, the frame counter and the match value are all zero, and `irq_o` is low.
- R2: The control word at address 0x00 holds source i (0..7) with its enable at bit 17+2i and its pending bit at bit 16+2i. Source 7 is the frame-count match. Source j, for j = 0..6, is `ext_evt_i[j]`: bit 6 is message flag, then new peak, clocks stopped, sync error, sync OK and new sample rate, and bit 0 is status flag. A write to 0x00 loads every enable bit from the written data.
- R3: When a source event occurs, its pending bit reads 1 after the next clock edge, whether or not its enable bit is set.
- R4: In a write to 0x00, a 1 at a pending position clears that pending bit and a 0 leaves it unchanged. An event in the same cycle as its clear leaves the bit set.
- R5: `irq_o` is high exactly when, for at least one source, both the enable bit and the pending bit are set.
- R6: The match value is read and written as a full word at address 0x50.
- R7: The frame counter at address 0x40 adds one on each cycle in which `frame_stb_i` is high and wraps from 0xFFFFFFFF to 0. A software write to 0x40 loads the written word and takes precedence over a strobe in the same cycle.
- R8: The frame-match event fires once, in the cycle after the counter and the match value become equal, whether they met through a strobe or through a write of either register. Source 7 pending is therefore visible one further edge later. The event does not repeat while the two stay equal, and it does not fire for the equality that holds out of reset.
- R9: Bits 15..0 of the control word read as zero, whatever is written there.
- R10: Any address other than 0x00, 0x40 and 0x50 reads as zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Byte address of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| ext_evt_i | input | 7 | Single-cycle event strobes for sources 0..6 |
| frame_stb_i | input | 1 | One-cycle strobe per audio frame |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions assume that the event inputs and the frame strobe are single-cycle pulses sampled on the clock. They also assume that each cycle carries at most one register write. The stimulus holds each input for exactly one cycle, and it drives every input at the falling edge, so a strobe is never sampled twice. Match values written during the random phase are placed a few frames ahead of the current count, so that the match event fires often and falls on cycles that also carry strobes and clears.

// File: rtl/aud_irq_pkg.sv
package aud_irq_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned ADDR_W   = 8;
    localparam int unsigned NUM_SRC  = 8;
    localparam int unsigned NUM_EXT  = NUM_SRC - 1;
    localparam int unsigned CNT_W    = 32;
    localparam int unsigned PAIR_LSB = DATA_W - 2 * NUM_SRC;

    localparam logic [ADDR_W-1:0] ADR_CTRL  = 8'h00;
    localparam logic [ADDR_W-1:0] ADR_COUNT = 8'h40;
    localparam logic [ADDR_W-1:0] ADR_MATCH = 8'h50;

    typedef struct packed {
        logic [NUM_SRC-1:0] en;
        logic [NUM_SRC-1:0] pend;
    } pend_state_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] match;
        logic             eq_seen;
    } frame_state_t;

    typedef struct packed {
        logic ctrl;
        logic count;
        logic match;
    } wr_sel_t;

endpackage

// File: rtl/aud_irq_regdec.sv
module aud_irq_regdec
    import aud_irq_pkg::*;
(
    input  logic               we_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [CNT_W-1:0]   cnt_i,
    input  logic [CNT_W-1:0]   match_i,
    output wr_sel_t            wr_o,
    output logic [DATA_W-1:0]  rdata_o
);

    logic [DATA_W-1:0] ctrl_word;

    assign ctrl_word[PAIR_LSB-1:0] = '0;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_pair
        assign ctrl_word[PAIR_LSB + 2*i + 1] = en_i[i];
        assign ctrl_word[PAIR_LSB + 2*i]     = pend_i[i];
    end

    always_comb begin
        wr_o       = '0;
        wr_o.ctrl  = we_i && (addr_i == ADR_CTRL);
        wr_o.count = we_i && (addr_i == ADR_COUNT);
        wr_o.match = we_i && (addr_i == ADR_MATCH);
    end

    always_comb begin
        unique case (addr_i)
            ADR_CTRL:  rdata_o = ctrl_word;
            ADR_COUNT: rdata_o = cnt_i;
            ADR_MATCH: rdata_o = match_i;
            default:   rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/aud_irq_frame_ctr.sv
module aud_irq_frame_ctr
    import aud_irq_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             stb_i,
    input  logic             cnt_wr_i,
    input  logic             match_wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] match_o,
    output logic             hit_o
);

    frame_state_t st_d, st_q;
    logic         equal_now;

    assign equal_now = (st_q.cnt == st_q.match);
    assign hit_o     = equal_now && !st_q.eq_seen;
    assign cnt_o     = st_q.cnt;
    assign match_o   = st_q.match;

    always_comb begin
        st_d         = st_q;
        st_d.eq_seen = equal_now;
        if (cnt_wr_i) begin
            st_d.cnt = wdata_i;
        end else if (stb_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (match_wr_i) begin
            st_d.match = wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.cnt     <= '0;
            st_q.match   <= '0;
            st_q.eq_seen <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/aud_irq_pend_bank.sv
module aud_irq_pend_bank
    import aud_irq_pkg::*;
(
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       wr_i,
    input  logic [DATA_W-1:PAIR_LSB]   wdata_i,
    input  logic [NUM_SRC-1:0]         set_i,
    output logic [NUM_SRC-1:0]         en_o,
    output logic [NUM_SRC-1:0]         pend_o
);

    pend_state_t        st_d, st_q;
    logic [NUM_SRC-1:0] en_nx;
    logic [NUM_SRC-1:0] pend_nx;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        localparam int unsigned EN_POS = PAIR_LSB + 2*i + 1;
        localparam int unsigned PD_POS = PAIR_LSB + 2*i;
        assign en_nx[i]   = wr_i ? wdata_i[EN_POS] : st_q.en[i];
        assign pend_nx[i] = set_i[i] | (st_q.pend[i] & ~(wr_i & wdata_i[PD_POS]));
    end

    always_comb begin
        st_d      = st_q;
        st_d.en   = en_nx;
        st_d.pend = pend_nx;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o   = st_q.en;
    assign pend_o = st_q.pend;

endmodule

// File: rtl/aud_evt_irq_unit.sv
module aud_evt_irq_unit
    import aud_irq_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              reg_we_i,
    input  logic [7:0]        reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    input  logic [6:0]        ext_evt_i,
    input  logic              frame_stb_i,
    output logic              irq_o
);

    wr_sel_t            wr_sel;
    logic [NUM_SRC-1:0] en_vec;
    logic [NUM_SRC-1:0] pend_vec;
    logic [NUM_SRC-1:0] src_set;
    logic [CNT_W-1:0]   frame_cnt;
    logic [CNT_W-1:0]   match_val;
    logic               match_pulse;

    assign src_set = {match_pulse, ext_evt_i};

    aud_irq_regdec u_dec (
        .we_i    (reg_we_i),
        .addr_i  (reg_addr_i),
        .en_i    (en_vec),
        .pend_i  (pend_vec),
        .cnt_i   (frame_cnt),
        .match_i (match_val),
        .wr_o    (wr_sel),
        .rdata_o (reg_rdata_o)
    );

    aud_irq_frame_ctr u_ctr (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .stb_i      (frame_stb_i),
        .cnt_wr_i   (wr_sel.count),
        .match_wr_i (wr_sel.match),
        .wdata_i    (reg_wdata_i),
        .cnt_o      (frame_cnt),
        .match_o    (match_val),
        .hit_o      (match_pulse)
    );

    aud_irq_pend_bank u_pend (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (wr_sel.ctrl),
        .wdata_i (reg_wdata_i[DATA_W-1:PAIR_LSB]),
        .set_i   (src_set),
        .en_o    (en_vec),
        .pend_o  (pend_vec)
    );

    assign irq_o = |(en_vec & pend_vec);

endmodule

// File: rtl/aud_evt_irq_chk.sv
module aud_evt_irq_chk
    import aud_irq_pkg::*;
(
    input logic               clk_i,
    input logic               rst_ni,
    input logic               reg_we_i,
    input logic [7:0]         reg_addr_i,
    input logic [31:0]        reg_rdata_o,
    input logic [6:0]         ext_evt_i,
    input logic               frame_stb_i,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] pend_vec,
    input logic [CNT_W-1:0]   frame_cnt,
    input logic               match_pulse
);

    logic [NUM_SRC-1:0] rd_en;
    logic [NUM_SRC-1:0] rd_pend;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_rd
        assign rd_en[i]   = reg_rdata_o[PAIR_LSB + 2*i + 1];
        assign rd_pend[i] = reg_rdata_o[PAIR_LSB + 2*i];
    end

    AST_EVT_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ext_evt_i != '0) |=> ((pend_vec[NUM_EXT-1:0] & $past(ext_evt_i)) == $past(ext_evt_i))); // R3

    AST_PEND_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(reg_we_i && reg_addr_i == ADR_CTRL) |=> ((pend_vec & $past(pend_vec)) == $past(pend_vec))); // R4

    AST_IRQ_MATCHES_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_addr_i == ADR_CTRL) |-> (irq_o == |(rd_en & rd_pend))); // R5

    AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frame_stb_i && !(reg_we_i && reg_addr_i == ADR_COUNT)) |=> (frame_cnt == $past(frame_cnt) + 1'b1)); // R7

    AST_MATCH_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        match_pulse |=> !match_pulse); // R8

    AST_MATCH_PENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        match_pulse |=> pend_vec[NUM_SRC-1]); // R8

    AST_LOW_HALF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_addr_i == ADR_CTRL) |-> (reg_rdata_o[PAIR_LSB-1:0] == '0)); // R9

    AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_addr_i != ADR_CTRL && reg_addr_i != ADR_COUNT && reg_addr_i != ADR_MATCH)
            |-> (reg_rdata_o == '0)); // R10

endmodule

bind aud_evt_irq_unit aud_evt_irq_chk chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_rdata_o (reg_rdata_o),
    .ext_evt_i   (ext_evt_i),
    .frame_stb_i (frame_stb_i),
    .irq_o       (irq_o),
    .pend_vec    (pend_vec),
    .frame_cnt   (frame_cnt),
    .match_pulse (match_pulse)
);

// File: tb/aud_evt_irq_unit_tb.sv
module aud_evt_irq_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [6:0]  evt = '0;
    logic        stb = 1'b0;
    logic        irq;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;

    logic [7:0]  m_en = '0;
    logic [7:0]  m_pend = '0;
    logic [31:0] m_cnt = '0;
    logic [31:0] m_match = '0;
    logic        m_eqp = 1'b1;

    always #5 clk = ~clk;

    aud_evt_irq_unit dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_ni),
        .reg_we_i    (we),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .ext_evt_i   (evt),
        .frame_stb_i (stb),
        .irq_o       (irq)
    );

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        logic [31:0] w = '0;
        case (a)
            8'h00: begin
                for (int i = 0; i < 8; i++) begin
                    w[17 + 2*i] = m_en[i];
                    w[16 + 2*i] = m_pend[i];
                end
            end
            8'h40:   w = m_cnt;
            8'h50:   w = m_match;
            default: w = '0;
        endcase
        return w;
    endfunction

    function automatic string addr_tag(input logic [7:0] a);
        case (a)
            8'h00:   return "R2";
            8'h40:   return "R7";
            8'h50:   return "R6";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] expv, input string tag);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, expv, $time);
        end
    endtask

    task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d,
                        input logic [6:0] ev, input logic st, input string tag);
        logic       hit;
        logic [7:0] clr;
        @(negedge clk);
        we = w; addr = a; wdata = d; evt = ev; stb = st;
        #1;
        check({31'd0, irq}, {31'd0, |(m_en & m_pend)}, (tag == "") ? "R5" : tag);
        if (!w) check(rdata, exp_read(a), (tag == "") ? addr_tag(a) : tag);
        @(posedge clk);
        hit   = (m_cnt == m_match) && !m_eqp;
        m_eqp = (m_cnt == m_match);
        clr   = '0;
        if (w && a == 8'h00) begin
            for (int i = 0; i < 8; i++) begin
                m_en[i] = d[17 + 2*i];
                clr[i]  = d[16 + 2*i];
            end
        end
        m_pend = (m_pend & ~clr) | {hit, ev};
        if (w && a == 8'h40)  m_cnt = d;
        else if (st)          m_cnt = m_cnt + 1;
        if (w && a == 8'h50)  m_match = d;
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        step(1'b0, a, 32'h0, 7'h0, 1'b0, tag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        step(1'b1, a, d, 7'h0, 1'b0, "");
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;

        // R1: reset state
        rd(8'h00, "R1");
        rd(8'h40, "R1");
        rd(8'h50, "R1");
        // R8: equality held from reset gives no match event
        repeat (3) rd(8'h00, "R8");

        // R9: low half ignores ones
        wr(8'h00, 32'h0000_FFFF);
        rd(8'h00, "R9");

        // R3: event with enable clear sets pending, irq stays low
        step(1'b0, 8'h00, 0, 7'h41, 1'b0, "R3");
        rd(8'h00, "R3");
        // R2 / R5: enable only status source
        wr(8'h00, 32'h0002_0000);
        rd(8'h00, "R5");
        // R4: clear and event in the same cycle, event wins
        step(1'b1, 8'h00, 32'h0003_0000, 7'h01, 1'b0, "R4");
        rd(8'h00, "R4");
        // R4: clear bit 0, keep message pending (write 0 at its slot)
        wr(8'h00, 32'h0003_0000);
        rd(8'h00, "R4");

        // R7: wrap, and write beats strobe
        wr(8'h40, 32'hFFFF_FFFE);
        step(1'b0, 8'h40, 0, 7'h0, 1'b1, "R7");
        step(1'b0, 8'h40, 0, 7'h0, 1'b1, "R7");
        rd(8'h40, "R7");
        step(1'b1, 8'h40, 32'h0000_0010, 7'h0, 1'b1, "R7");
        rd(8'h40, "R7");

        // R8: match reached by strobe
        wr(8'h00, 32'hAAAA_0000);
        wr(8'h50, 32'h0000_0012);
        step(1'b0, 8'h00, 0, 7'h0, 1'b1, "R8");
        step(1'b0, 8'h00, 0, 7'h0, 1'b1, "R8");
        rd(8'h00, "R8");
        rd(8'h00, "R8");
        // R8: clear while equal, no repeat
        wr(8'h00, 32'hFFFF_0000);
        repeat (3) rd(8'h00, "R8");
        // R8: match reached by writing the match value
        wr(8'h50, 32'h0000_0040);
        wr(8'h50, 32'h0000_0012);
        rd(8'h00, "R8");
        rd(8'h00, "R8");

        // R10: unmapped write changes nothing
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h20, "R10");
        rd(8'h00, "R10");
        rd(8'h40, "R10");
        rd(8'h50, "R10");

        // random phase
        for (int n = 0; n < 4000; n++) begin
            logic        w;
            logic [7:0]  a;
            logic [31:0] d;
            logic [6:0]  ev;
            int unsigned sel;
            w   = ($urandom_range(0, 3) == 0);
            sel = $urandom_range(0, 9);
            a   = (sel < 4) ? 8'h00 : (sel < 6) ? 8'h40 : (sel < 8) ? 8'h50 : 8'($urandom_range(1, 255));
            d   = $urandom();
            if (a == 8'h50) d = m_cnt + $urandom_range(0, 4);
            if (a == 8'h40 && $urandom_range(0, 3) == 0) d = 32'hFFFF_FFFF;
            ev = '0;
            for (int b = 0; b < 7; b++) ev[b] = ($urandom_range(0, 15) == 0);
            step(w, a, d, ev, ($urandom_range(0, 2) == 0), "");
        end

        rd(8'h00, "R2");
        finish_run();
    end

endmodule